// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Sequencer

This block sits behind a two-wire serial memory bus controller. The controller opens a write transaction with a starting array address, then hands over received data bytes one by one. The block gathers them into a page buffer of `PAGE_BYTES` entries. Within the buffer, the position advances only in the low address bits, so the page itself never changes during a transaction.

When the controller reports the stop condition that closes the transaction, the block starts a self-timed programming cycle. It copies only the bytes that actually arrived into a register-modelled storage array. For `PROG_CYCLES` clock cycles it holds `busy` high. This count is the stand-in for the real erase and program time, nominally 5 ms and at most 10 ms. While `busy` is high the block takes no requests, so a master that polls for an acknowledge gets none until the cycle ends.

A transaction that is abandoned never programs anything. This covers a dummy write cut short by a repeated start, and a stop that arrives with no data. When a cycle completes, the block reports the address that follows the last written byte, wrapped within the page, so the controller can load its address counter. A separate read port gives access to the array.

Top module: `eeprom_page_prog`

## Requirements
- R1: After reset, `busy` and `next_vld` are 0. Every array byte reads 0xFF until it is programmed.
- R2: Data bytes are placed at consecutive addresses starting at `wr_addr`. They reach the array only after `xfer_stop`.
- R3: After each byte only address bits [3:0] advance, wrapping from 0xF to 0x0. Bits [10:4] keep the page given by `wr_addr`.
- R4: If more than 16 bytes arrive before the stop, later bytes overwrite the earlier ones at the same wrapped offsets.
- R5: Array bytes in the page that received no data in the transaction keep their previous contents.
- R6: `busy` rises in the cycle after the clock edge that samples `xfer_stop`, and stays high for exactly `PROG_CYCLES` cycles.
- R7: While `busy` is 1, `wr_start`, `byte_vld` and `xfer_stop` have no effect. The array, `next_addr` and `busy` behave as if those inputs were absent.
- R8: `xfer_abort`, or a `xfer_stop` with no data byte received, starts no programming. `busy` stays 0 and the array is unchanged.
- R9: In the cycle after `busy` falls, `next_vld` is 1 for one cycle. `next_addr` holds {page bits [10:4], offset following the last written byte}.
- R10: `rd_data` shows the array byte at `rd_addr` one clock after `rd_addr` is sampled.
- R11: A transaction with a single data byte programs just that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Opens a write transaction at `wr_addr` |
| wr_addr | input | 11 | Starting array address of the transaction |
| byte_vld | input | 1 | One received data byte on `byte_data` |
| byte_data | input | 8 | Data byte |
| xfer_stop | input | 1 | Stop condition closing the transaction |
| xfer_abort | input | 1 | Repeated start or abandonment; discards the buffer |
| rd_addr | input | 11 | Read port address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Programming cycle in progress |
| next_addr | output | 11 | Address following the last programmed byte |
| next_vld | output | 1 | One-cycle pulse when `next_addr` is updated |

## Verification
The hardest situation to reach is a complete transaction that arrives while programming is already under way. The block must then ignore the start, the data and the stop, and it must not start a second cycle once the first one ends. The stimulus reaches this state by issuing a write, waiting one cycle after the stop so that `busy` is high, and then driving a full transaction to a different page. It then checks that this page still reads 0xFF, that `busy` stays low afterwards, and that `next_addr` still reflects the first write. Page wrap and overflow are brought about by starting near the end of a page and by sending seventeen bytes. Unwritten neighbours in the page are read back to show they kept their old values.

// File: rtl/eeprom_page_pkg.sv
package eeprom_page_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_PROG = 1'b1
  } seq_state_t;
endpackage

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int BASE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              clear,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              xfer_stop,
  input  logic              xfer_abort,
  input  logic [OFF_W-1:0]  sel_idx,
  output logic [DATA_W-1:0] sel_data,
  output logic              sel_valid,
  output logic [BASE_W-1:0] page_base,
  output logic [OFF_W-1:0]  wr_ptr,
  output logic              commit
);

  logic                  active_q;
  logic [PAGE_BYTES-1:0] valid_q;
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic                  take_byte;

  assign take_byte = !busy && active_q && byte_vld && !xfer_abort && !wr_start;
  assign commit    = !busy && active_q && xfer_stop && !xfer_abort && (|valid_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      page_base <= '0;
      wr_ptr    <= '0;
    end else if (!busy) begin
      if (xfer_abort) begin
        active_q <= 1'b0;
      end else if (wr_start) begin
        active_q  <= 1'b1;
        page_base <= wr_addr[ADDR_W-1:OFF_W];
        wr_ptr    <= wr_addr[OFF_W-1:0];
      end else if (xfer_stop) begin
        active_q <= 1'b0;
      end else if (take_byte) begin
        wr_ptr <= wr_ptr + 1'b1;
      end
    end
  end

  generate
    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          valid_q[s] <= 1'b0;
        end else if (clear) begin
          valid_q[s] <= 1'b0;
        end else if (!busy && (xfer_abort || wr_start)) begin
          valid_q[s] <= 1'b0;
        end else if (take_byte && wr_ptr == OFF_W'(s)) begin
          valid_q[s] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (take_byte && wr_ptr == OFF_W'(s)) begin
          slot_q[s] <= byte_data;
        end
      end
    end
  endgenerate

  assign sel_data  = slot_q[sel_idx];
  assign sel_valid = valid_q[sel_idx];

  // R7
  buf_frozen_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(page_base) && $stable(wr_ptr)));

  // R3
  page_fixed_across_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    take_byte |=> $stable(page_base));

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
  import eeprom_page_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 200,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int BASE_W     = ADDR_W - OFF_W,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [BASE_W-1:0] page_base,
  input  logic [OFF_W-1:0]  wr_ptr,
  input  logic              sel_valid,
  input  logic [DATA_W-1:0] sel_data,
  output logic [OFF_W-1:0]  sel_idx,
  output logic              clear,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] next_addr,
  output logic              next_vld
);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_cyc;
  logic             copying;

  assign last_cyc  = (state_q == SEQ_PROG) && (cnt_q == CNT_W'(PROG_CYCLES - 1));
  assign copying   = (state_q == SEQ_PROG) && (cnt_q < CNT_W'(PAGE_BYTES));
  assign sel_idx   = cnt_q[OFF_W-1:0];
  assign clear     = last_cyc;
  assign mem_we    = copying && sel_valid;
  assign mem_waddr = {page_base, sel_idx};
  assign mem_wdata = sel_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      cnt_q     <= '0;
      busy      <= 1'b0;
      next_vld  <= 1'b0;
      next_addr <= '0;
    end else begin
      next_vld <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (commit) begin
            state_q <= SEQ_PROG;
            busy    <= 1'b1;
            cnt_q   <= '0;
          end
        end
        SEQ_PROG: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_cyc) begin
            state_q   <= SEQ_IDLE;
            busy      <= 1'b0;
            next_vld  <= 1'b1;
            next_addr <= {page_base, wr_ptr};
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R6
  busy_needs_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(commit));

  // R6
  busy_window_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q < CNT_W'(PROG_CYCLES)));

  // R9
  done_reports_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> next_vld);

endmodule

// File: rtl/storage_array.sv
module storage_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/eeprom_page_prog.sv
module eeprom_page_prog #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 200,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int BASE_W     = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              xfer_stop,
  input  logic              xfer_abort,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [ADDR_W-1:0] next_addr,
  output logic              next_vld
);

  logic [OFF_W-1:0]  sel_idx;
  logic [DATA_W-1:0] sel_data;
  logic              sel_valid;
  logic [BASE_W-1:0] page_base;
  logic [OFF_W-1:0]  wr_ptr;
  logic              commit;
  logic              clear;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  page_buffer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_buf (
    .clk(clk), .rst(rst), .busy(busy), .clear(clear),
    .wr_start(wr_start), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .xfer_stop(xfer_stop), .xfer_abort(xfer_abort),
    .sel_idx(sel_idx), .sel_data(sel_data), .sel_valid(sel_valid),
    .page_base(page_base), .wr_ptr(wr_ptr), .commit(commit)
  );

  prog_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
    .PROG_CYCLES(PROG_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .commit(commit),
    .page_base(page_base), .wr_ptr(wr_ptr),
    .sel_valid(sel_valid), .sel_data(sel_data), .sel_idx(sel_idx),
    .clear(clear), .busy(busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .next_addr(next_addr), .next_vld(next_vld)
  );

  storage_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // R2
  array_write_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R3
  array_write_in_page_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_waddr[ADDR_W-1:OFF_W] == page_base));

  // R8
  abort_no_program_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_abort && !busy) |=> !busy);

endmodule

// File: tb/eeprom_page_prog_bench.sv
module eeprom_page_prog_bench;
  localparam int PROG = 200;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_start, byte_vld, xfer_stop, xfer_abort;
  logic [10:0] wr_addr, rd_addr;
  logic [7:0]  byte_data;
  logic [7:0]  rd_data;
  logic        busy, next_vld;
  logic [10:0] next_addr;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [2048];
  logic [7:0] pay [32];

  always #10 clk = ~clk;

  eeprom_page_prog #(.PROG_CYCLES(PROG)) u_eeprom_page_prog (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .xfer_stop(xfer_stop),
    .xfer_abort(xfer_abort), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .next_addr(next_addr), .next_vld(next_vld)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_start = 0; byte_vld = 0; xfer_stop = 0; xfer_abort = 0;
  endtask

  task automatic pulse_start(input logic [10:0] a);
    @(negedge clk); idle_inputs(); wr_start = 1; wr_addr = a;
    @(negedge clk); idle_inputs();
  endtask

  task automatic pulse_byte(input logic [7:0] d);
    @(negedge clk); idle_inputs(); byte_vld = 1; byte_data = d;
    @(negedge clk); idle_inputs();
  endtask

  task automatic pulse_stop();
    @(negedge clk); idle_inputs(); xfer_stop = 1;
  endtask

  task automatic read_check(input string req, input logic [10:0] a, input logic [7:0] exp);
    @(negedge clk); idle_inputs(); rd_addr = a;
    @(negedge clk);
    check(req, int'(rd_data), int'(exp));
  endtask

  // Waits out the cycle after a stop was driven; checks R6 and R9.
  task automatic wait_prog(input logic [10:0] exp_next);
    int n = 0;
    @(negedge clk); idle_inputs();
    while (busy) begin n++; @(negedge clk); end
    check("R6 busy length", n, PROG);
    check("R9 next_vld", int'(next_vld), 1);
    check("R9 next_addr", int'(next_addr), int'(exp_next));
    @(negedge clk);
    check("R9 next_vld one cycle", int'(next_vld), 0);
  endtask

  task automatic page_write(input string req, input logic [10:0] a, input int n);
    logic [3:0] off = a[3:0];
    pulse_start(a);
    for (int i = 0; i < n; i++) begin
      pulse_byte(pay[i]);
      model[{a[10:4], off}] = pay[i];
      off = off + 1'b1;
    end
    pulse_stop();
    wait_prog({a[10:4], off});
    for (int i = 0; i < 16; i++)
      read_check(req, {a[10:4], 4'(i)}, model[{a[10:4], 4'(i)}]);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 next_vld", int'(next_vld), 0);
    read_check("R1 erased", 11'h000, 8'hFF);
    read_check("R10 erased", 11'h7FF, 8'hFF);
  endtask

  task automatic t_single();
    pay[0] = 8'hA5;
    page_write("R11 single byte", 11'h123, 1);
  endtask

  task automatic t_seq();
    for (int i = 0; i < 5; i++) pay[i] = 8'(8'h30 + i);
    page_write("R2 consecutive", 11'h0A0, 5);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 4; i++) pay[i] = 8'(8'hC0 + i);
    page_write("R3 wrap in page", 11'h2FE, 4);
    read_check("R3 next page untouched", 11'h300, 8'hFF);
  endtask

  task automatic t_over();
    for (int i = 0; i < 17; i++) pay[i] = 8'(8'h50 + i);
    page_write("R4 overflow", 11'h400, 17);
    read_check("R4 first slot overwritten", 11'h400, 8'h60);
  endtask

  task automatic t_keep();
    pay[0] = 8'h77;
    page_write("R5 neighbours kept", 11'h125, 1);
    read_check("R5 old byte", 11'h123, 8'hA5);
  endtask

  task automatic t_abort();
    pulse_start(11'h500);
    @(negedge clk); idle_inputs(); xfer_abort = 1;
    @(negedge clk); idle_inputs();
    check("R8 abort before data", int'(busy), 0);
    pulse_start(11'h510);
    pulse_byte(8'h11);
    @(negedge clk); idle_inputs(); xfer_abort = 1;
    @(negedge clk); idle_inputs(); xfer_stop = 1;
    @(negedge clk); idle_inputs();
    check("R8 abort after data", int'(busy), 0);
    pulse_start(11'h520);
    pulse_stop();
    @(negedge clk); idle_inputs();
    check("R8 stop no data", int'(busy), 0);
    read_check("R8 array", 11'h510, 8'hFF);
    read_check("R8 array", 11'h500, 8'hFF);
  endtask

  task automatic t_busy_ignore();
    int n = 0;
    pulse_start(11'h600);
    pulse_byte(8'h9C);
    pulse_stop();
    @(negedge clk); idle_inputs();
    check("R7 busy up", int'(busy), 1);
    wr_start = 1; wr_addr = 11'h700;
    @(negedge clk); idle_inputs(); byte_vld = 1; byte_data = 8'h12;
    @(negedge clk); idle_inputs(); byte_vld = 1; byte_data = 8'h34;
    @(negedge clk); idle_inputs(); xfer_stop = 1;
    @(negedge clk); idle_inputs();
    while (busy) begin n++; @(negedge clk); end
    check("R7 next_addr", int'(next_addr), 11'h601);
    for (int i = 0; i < 5; i++) @(negedge clk);
    check("R7 no second cycle", int'(busy), 0);
    read_check("R7 ignored page", 11'h700, 8'hFF);
    read_check("R7 ignored page", 11'h701, 8'hFF);
    read_check("R7 first write", 11'h600, 8'h9C);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
    idle_inputs(); wr_addr = '0; byte_data = '0; rd_addr = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single();
    t_seq();
    t_wrap();
    t_over();
    t_keep();
    t_abort();
    t_busy_ignore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule